// File: doc/BRIEF.md
# Serial EEPROM Station Address Autoloader

This block fills a 48-bit station address register from a 3-wire serial EEPROM that holds 128 bytes. An attempt runs after the asynchronous reset is released and again each time a soft-reset request pulse arrives. The loader first reads location 0. If that byte holds the signature A5h, it reads locations 1 to 6 and stores them into the address register, the lowest byte first. It then raises a sticky loaded flag. If any other value is found at location 0, the attempt ends and the register keeps its previous contents.

Every read is a self-contained frame on the serial pins:
- chip select goes high;
- a start bit and a two-bit read opcode go out;
- the seven address bits follow;
- the memory returns a dummy zero and then eight data bits.

The serial clock is derived from the system clock by a parameterised divider. Chip select rests low for at least one serial clock period between frames. A busy flag covers the whole attempt, and a one-cycle done pulse marks its end.

Top module: `eeprom_addr_loader`

## Requirements
- R1: An attempt starts when rst_ni is released and again in the cycle after any cycle with soft_rst_i high. From that cycle busy_o is 1 and loaded_o is 0.
- R2: Each read frame holds ee_cs_o high. The bits sent on ee_di_o are the start bit 1, then opcode bits 1 and 0, then the 7-bit location, most significant bit first. ee_sk_o is high only while ee_cs_o is high.
- R3: ee_di_o changes only when ee_sk_o falls. ee_do_i is sampled when ee_sk_o rises. The eleventh rising edge carries a dummy bit, which is discarded. Rising edges 12 to 19 carry the data byte, most significant bit first.
- R4: The first read of every attempt is location 0. If that byte is not A5h, the attempt ends after this single read. In that case station_addr_o is unchanged and loaded_o stays 0.
- R5: When the signature matches, locations 1 to 6 are read in ascending order. The byte from location n lands in station_addr_o[8n-1:8n-8].
- R6: loaded_o rises in the cycle the sixth byte is stored and holds until the next attempt starts.
- R7: Between two frames, ee_cs_o stays low for at least 2*CLK_DIV system clock cycles, which is one serial clock period. This also applies after an aborted frame.
- R8: busy_o stays high from the start of an attempt until it ends. done_o pulses for exactly one cycle, in the cycle busy_o falls.
- R9: A soft_rst_i pulse during an attempt cuts the current frame short and starts again from location 0.
- R10: Each half period of ee_sk_o lasts CLK_DIV system clock cycles, so successive rising edges within a frame are 2*CLK_DIV cycles apart.
- R11: While rst_ni is low, station_addr_o is 0, loaded_o is 0, and ee_cs_o, ee_sk_o and ee_di_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release starts an attempt |
| soft_rst_i | input | 1 | Synchronous request to restart the autoload attempt |
| ee_do_i | input | 1 | Serial data returned by the EEPROM |
| ee_cs_o | output | 1 | EEPROM chip select, active high |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data sent to the EEPROM |
| busy_o | output | 1 | Autoload attempt in progress |
| done_o | output | 1 | One-cycle pulse when an attempt ends |
| loaded_o | output | 1 | Sticky flag: all six address bytes stored |
| station_addr_o | output | 48 | Station address, byte 0 in bits 7:0 |

## Verification
The assertions take soft_rst_i to be synchronous to clk_i. They also take the serial memory to be passive: it can only move ee_do_i and cannot stall or lengthen a frame, so every frame timing property depends on the design alone.

The bench memory model meets these conditions. It is evaluated on the falling system clock edge, updates ee_do_i only just after a rising serial clock edge, and returns the dummy zero before the data byte. soft_rst_i and rst_ni are changed just after a rising system clock edge. Soft resets are placed in idle periods as well as in the middle of a frame, so the abort path and the restart gap are both exercised.

// File: rtl/eal_pkg.sv
package eal_pkg;
  localparam int unsigned OPC_W  = 2;
  localparam logic [1:0]  OPC_RD = 2'b10;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {LD_START, LD_SIG, LD_BYTE, LD_IDLE} ld_state_e;
  typedef enum logic [1:0] {SH_IDLE, SH_RUN, SH_GAP} sh_state_e;
endpackage

// File: rtl/eal_sclk_gen.sv
module eal_sclk_gen #(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             sk_q;
  logic             tick;

  assign tick = en_i && (cnt_q == CNT_W'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sk_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      sk_q  <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sk_q  <= ~sk_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign sk_o   = sk_q;
  assign rise_o = tick & ~sk_q;
  assign fall_o = tick & sk_q;
endmodule

// File: rtl/eal_read_engine.sv
module eal_read_engine
  import eal_pkg::*;
#(
  parameter int unsigned CLK_DIV = 2,
  parameter int unsigned AW      = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              req_i,
  input  logic [AW-1:0]     addr_i,
  output logic              idle_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  input  logic              do_i
);
  localparam int unsigned CMD_W       = 1 + OPC_W + AW;
  localparam int unsigned FRAME_RISES = CMD_W + 1 + BYTE_W;
  localparam int unsigned RC_W        = $clog2(FRAME_RISES + 1);
  localparam int unsigned GAP_CYC     = 2 * CLK_DIV;
  localparam int unsigned GAP_W       = $clog2(GAP_CYC + 1);

  sh_state_e          state_q;
  logic [RC_W-1:0]    rc_q;
  logic [CMD_W-1:0]   sr_q;
  logic [BYTE_W-1:0]  shin_q;
  logic [GAP_W-1:0]   gap_q;
  logic               cs_q, di_q, done_q;
  logic               sk_en, sk_rise, sk_fall;
  logic [CMD_W-1:0]   cmd;

  assign cmd   = {1'b1, OPC_RD, addr_i};
  // gate on abort so the clock drops in the same edge as chip select
  assign sk_en = (state_q == SH_RUN) && !abort_i;

  eal_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sk_en),
    .sk_o   (sk_o),
    .rise_o (sk_rise),
    .fall_o (sk_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SH_IDLE;
      rc_q    <= '0;
      sr_q    <= '0;
      shin_q  <= '0;
      gap_q   <= '0;
      cs_q    <= 1'b0;
      di_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        // an aborted frame still owes the memory its deselect gap
        cs_q    <= 1'b0;
        di_q    <= 1'b0;
        rc_q    <= '0;
        gap_q   <= '0;
        state_q <= (state_q == SH_IDLE) ? SH_IDLE : SH_GAP;
      end else begin
        unique case (state_q)
          SH_IDLE: if (req_i) begin
            cs_q    <= 1'b1;
            di_q    <= cmd[CMD_W-1];
            sr_q    <= {cmd[CMD_W-2:0], 1'b0};
            rc_q    <= '0;
            state_q <= SH_RUN;
          end
          SH_RUN: begin
            if (sk_rise) begin
              rc_q <= rc_q + RC_W'(1);
              if (rc_q >= RC_W'(CMD_W + 1)) shin_q <= {shin_q[BYTE_W-2:0], do_i};
            end
            if (sk_fall) begin
              if (rc_q == RC_W'(FRAME_RISES)) begin
                cs_q    <= 1'b0;
                di_q    <= 1'b0;
                gap_q   <= '0;
                state_q <= SH_GAP;
              end else if (rc_q < RC_W'(CMD_W)) begin
                di_q <= sr_q[CMD_W-1];
                sr_q <= {sr_q[CMD_W-2:0], 1'b0};
              end else begin
                di_q <= 1'b0;
              end
            end
          end
          SH_GAP: begin
            if (gap_q == GAP_W'(GAP_CYC - 1)) begin
              state_q <= SH_IDLE;
              done_q  <= 1'b1;
            end else begin
              gap_q <= gap_q + GAP_W'(1);
            end
          end
          default: state_q <= SH_IDLE;
        endcase
      end
    end
  end

  assign idle_o = (state_q == SH_IDLE);
  assign done_o = done_q;
  assign data_o = shin_q;
  assign cs_o   = cs_q;
  assign di_o   = di_q;
endmodule

// File: rtl/eal_addr_lanes.sv
module eal_addr_lanes #(
  parameter int unsigned NUM_BYTES = 6,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       sel_i,
  input  logic [7:0]             byte_i,
  output logic [NUM_BYTES*8-1:0] addr_o
);
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               lane_q <= '0;
      else if (we_i && sel_i == IDX_W'(g))       lane_q <= byte_i;
    end
    assign addr_o[g*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/eeprom_addr_loader.sv
module eeprom_addr_loader
  import eal_pkg::*;
#(
  parameter int unsigned CLK_DIV   = 2,
  parameter int unsigned MEM_AW    = 7,
  parameter int unsigned NUM_BYTES = 6,
  parameter logic [7:0]  SIG_BYTE  = 8'hA5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   soft_rst_i,
  input  logic                   ee_do_i,
  output logic                   ee_cs_o,
  output logic                   ee_sk_o,
  output logic                   ee_di_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   loaded_o,
  output logic [NUM_BYTES*8-1:0] station_addr_o
);
  localparam int unsigned IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  ld_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [MEM_AW-1:0] raddr_q;
  logic              req_q, loaded_q, done_q;
  logic              rd_idle, rd_done;
  logic [7:0]        rd_data;
  logic              lane_we;

  eal_read_engine #(.CLK_DIV(CLK_DIV), .AW(MEM_AW)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (soft_rst_i),
    .req_i   (req_q),
    .addr_i  (raddr_q),
    .idle_o  (rd_idle),
    .done_o  (rd_done),
    .data_o  (rd_data),
    .cs_o    (ee_cs_o),
    .sk_o    (ee_sk_o),
    .di_o    (ee_di_o),
    .do_i    (ee_do_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= LD_START;
      idx_q    <= '0;
      raddr_q  <= '0;
      req_q    <= 1'b0;
      loaded_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      if (soft_rst_i) begin
        state_q  <= LD_START;
        loaded_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        unique case (state_q)
          LD_START: begin
            loaded_q <= 1'b0;
            idx_q    <= '0;
            // wait out any deselect gap left by an aborted frame
            if (rd_idle) begin
              raddr_q <= '0;
              req_q   <= 1'b1;
              state_q <= LD_SIG;
            end
          end
          LD_SIG: if (rd_done) begin
            if (rd_data == SIG_BYTE) begin
              raddr_q <= MEM_AW'(1);
              req_q   <= 1'b1;
              state_q <= LD_BYTE;
            end else begin
              done_q  <= 1'b1;
              state_q <= LD_IDLE;
            end
          end
          LD_BYTE: if (rd_done) begin
            if (idx_q == IDX_W'(NUM_BYTES - 1)) begin
              loaded_q <= 1'b1;
              done_q   <= 1'b1;
              state_q  <= LD_IDLE;
            end else begin
              idx_q   <= idx_q + IDX_W'(1);
              raddr_q <= raddr_q + MEM_AW'(1);
              req_q   <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign lane_we = (state_q == LD_BYTE) && rd_done && !soft_rst_i;

  eal_addr_lanes #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_lanes (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (lane_we),
    .sel_i  (idx_q),
    .byte_i (rd_data),
    .addr_o (station_addr_o)
  );

  assign busy_o   = (state_q != LD_IDLE);
  assign done_o   = done_q;
  assign loaded_o = loaded_q;
endmodule

// File: rtl/eal_checker.sv
module eal_checker #(
  parameter int unsigned CLK_DIV   = 2,
  parameter int unsigned ADDR_BITS = 48
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 soft_rst_i,
  input logic                 ee_cs_o,
  input logic                 ee_sk_o,
  input logic                 ee_di_o,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 loaded_o,
  input logic [ADDR_BITS-1:0] station_addr_o
);
  localparam int unsigned GAP = 2 * CLK_DIV;
  localparam int unsigned LW  = $clog2(GAP + 1);

  logic [LW-1:0] low_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       low_cnt <= LW'(GAP);
    else if (ee_cs_o)                  low_cnt <= '0;
    else if (low_cnt != LW'(GAP))      low_cnt <= low_cnt + LW'(1);
  end

  // R1
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> busy_o && !loaded_o);
  // R2
  sk_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_sk_o |-> ee_cs_o);
  // R3
  di_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_sk_o |-> $stable(ee_di_o));
  // R4
  addr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(station_addr_o) |-> $past(busy_o));
  // R6
  loaded_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loaded_o) |-> done_o);
  // R6
  busy_loaded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && loaded_o));
  // R7
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ee_cs_o) |-> low_cnt == LW'(GAP));
  // R8
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
endmodule

bind eeprom_addr_loader eal_checker #(.CLK_DIV(CLK_DIV), .ADDR_BITS(NUM_BYTES*8)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .soft_rst_i     (soft_rst_i),
  .ee_cs_o        (ee_cs_o),
  .ee_sk_o        (ee_sk_o),
  .ee_di_o        (ee_di_o),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .loaded_o       (loaded_o),
  .station_addr_o (station_addr_o)
);

// File: tb/tb_eeprom_addr_loader.sv
`timescale 1ns/1ps
module tb_eeprom_addr_loader;
  localparam int CLK_DIV = 2;
  localparam int GAP     = 2 * CLK_DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        ee_do = 1'b0;
  logic        ee_cs, ee_sk, ee_di, busy, done, loaded;
  logic [47:0] st_addr;

  always #4 clk = ~clk;

  eeprom_addr_loader #(.CLK_DIV(CLK_DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .ee_do_i(ee_do),
    .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di), .busy_o(busy),
    .done_o(done), .loaded_o(loaded), .station_addr_o(st_addr)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [128];

  // memory model, evaluated on falling system clock edge
  int log_addr [32];
  int log_n = 0, partial_n = 0, bad_hdr = 0, done_cnt = 0;
  int min_gap = 999, min_sp = 999, max_sp = 0;
  int bitcnt = 0, low_cnt = 999, since_rise = 0;
  logic [9:0] hdr = '0;
  logic prev_cs = 1'b0, prev_sk = 1'b0;

  always @(negedge clk) begin
    if (done) done_cnt++;
    since_rise++;
    if (!ee_cs) begin
      if (prev_cs) begin
        if (bitcnt == 19 && hdr[9:7] == 3'b110) begin
          if (log_n < 32) log_addr[log_n] = int'(hdr[6:0]);
          log_n++;
        end else if (bitcnt == 19) bad_hdr++;
        else partial_n++;
      end
      bitcnt = 0;
      ee_do  = 1'b0;
      low_cnt++;
    end else begin
      if (!prev_cs) begin
        if (low_cnt < min_gap) min_gap = low_cnt;
        low_cnt = 0;
      end
      if (ee_sk && !prev_sk) begin
        bitcnt++;
        if (bitcnt > 1) begin
          if (since_rise < min_sp) min_sp = since_rise;
          if (since_rise > max_sp) max_sp = since_rise;
        end
        since_rise = 0;
        if (bitcnt <= 10) hdr = {hdr[8:0], ee_di};
        if (bitcnt == 10) ee_do = 1'b0;
        else if (bitcnt >= 11 && bitcnt <= 18) ee_do = mem[hdr[6:0]][18-bitcnt];
      end
    end
    prev_cs = ee_cs;
    prev_sk = ee_sk;
  end

  function automatic logic [7:0] fb(int seed, int a);
    return 8'((a * 29 + seed * 53 + 7) & 255);
  endfunction

  function automatic logic [47:0] exp_addr(int seed);
    logic [47:0] e;
    for (int n = 0; n < 6; n++) e[n*8 +: 8] = fb(seed, n + 1);
    return e;
  endfunction

  task automatic fill(int seed, logic [7:0] sig);
    for (int a = 0; a < 128; a++) mem[a] = fb(seed, a);
    mem[0] = sig;
  endtask

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    log_n = 0; partial_n = 0; bad_hdr = 0; done_cnt = 0;
    min_gap = 999; min_sp = 999; max_sp = 0;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wait_idle();
    int k;
    k = 0;
    while (busy && k < 5000) begin step(1); k++; end
    chk(!busy, "R8 attempt ends", 64'(busy), 64'(0));
    step(2);
  endtask

  task automatic pulse_soft();
    @(posedge clk); #1 soft_rst = 1'b1;
    @(posedge clk); #1 soft_rst = 1'b0;
  endtask

  task automatic check_full_load(int seed, string tag);
    chk(st_addr == exp_addr(seed), {tag, " R5 address bytes"}, 64'(st_addr), 64'(exp_addr(seed)));
    chk(loaded, {tag, " R6 loaded set"}, 64'(loaded), 64'(1));
    chk(log_n == 7, {tag, " R4 R5 read count"}, 64'(log_n), 64'(7));
    for (int i = 0; i < 7 && i < log_n; i++)
      chk(log_addr[i] == i, {tag, " R4 R5 read order"}, 64'(log_addr[i]), 64'(i));
    chk(bad_hdr == 0, {tag, " R2 header"}, 64'(bad_hdr), 64'(0));
    chk(min_gap >= GAP, {tag, " R7 deselect gap"}, 64'(min_gap), 64'(GAP));
    chk(min_sp == GAP && max_sp == GAP, {tag, " R10 sk period"}, 64'(min_sp), 64'(GAP));
    chk(done_cnt == 1, {tag, " R8 done pulse"}, 64'(done_cnt), 64'(1));
    chk({ee_cs, ee_sk, ee_di} == 3'b000, {tag, " R11 idle pins"}, 64'({ee_cs, ee_sk, ee_di}), 64'(0));
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] keep;
    logic [7:0]  bad;
    fill(0, 8'hA5);
    step(5);
    // R11
    chk(st_addr == '0 && !loaded, "R11 reset state", 64'(st_addr), 64'(0));
    chk({ee_cs, ee_sk, ee_di} == 3'b000, "R11 reset pins", 64'({ee_cs, ee_sk, ee_di}), 64'(0));
    rst_n = 1'b1;
    step(1);
    chk(busy && !loaded, "R1 power-up start", 64'({busy, loaded}), 64'(2));
    wait_idle();
    check_full_load(0, "powerup");

    // R4 mismatch sweep: every single-bit corruption of the signature plus zero
    for (int b = 0; b <= 8; b++) begin
      bad  = (b == 8) ? 8'h00 : (8'hA5 ^ (8'h01 << b));
      keep = st_addr;
      fill(b + 10, bad);
      clear_log();
      pulse_soft();
      chk(busy && !loaded, "R1 soft start", 64'({busy, loaded}), 64'(2));
      wait_idle();
      chk(st_addr == keep, "R4 address kept", 64'(st_addr), 64'(keep));
      chk(!loaded, "R4 loaded stays low", 64'(loaded), 64'(0));
      chk(log_n == 1 && log_addr[0] == 0, "R4 single read at 0", 64'(log_n), 64'(1));
      chk(done_cnt == 1, "R8 done on mismatch", 64'(done_cnt), 64'(1));
    end

    // R5 R6 content sweep
    for (int s = 1; s <= 4; s++) begin
      fill(s, 8'hA5);
      clear_log();
      pulse_soft();
      chk(!loaded, "R6 cleared at attempt start", 64'(loaded), 64'(0));
      wait_idle();
      check_full_load(s, "sweep");
    end

    // R9 abort mid-attempt
    fill(7, 8'hA5);
    pulse_soft();
    step(200);
    chk(busy && !loaded, "R9 mid-attempt busy", 64'({busy, loaded}), 64'(2));
    clear_log();
    pulse_soft();
    chk(!ee_cs && !ee_sk, "R9 frame cut", 64'({ee_cs, ee_sk}), 64'(0));
    wait_idle();
    chk(partial_n == 1, "R9 one frame cut short", 64'(partial_n), 64'(1));
    check_full_load(7, "abort");

    // R1 R11 hard reset
    @(posedge clk); #1 rst_n = 1'b0;
    step(3);
    chk(st_addr == '0 && !loaded, "R11 hard reset clears", 64'(st_addr), 64'(0));
    fill(9, 8'hA5);
    clear_log();
    #1 rst_n = 1'b1;
    step(1);
    chk(busy, "R1 hard reset restart", 64'(busy), 64'(1));
    wait_idle();
    check_full_load(9, "hardrst");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule